// File: doc/BRIEF.md
# Threaded Pixel Width Converter

This block sits between a pixel fetch fabric and a camera serial transmitter. Each incoming 128-bit pixel word carries a 5-bit thread ID. A 32-entry context table, indexed by that ID, decides three things for the word. It decides whether the word is forwarded at all. It gives the slice width that cuts the word into narrower transfers. It gives the virtual channel and data type that tag each transfer. The forwarded slices leave one per clock on a 32-bit output stream. Narrow slices are zero-extended to the full width.

Two programmable timers space the traffic. The line timer limits how often a line may start. The frame timer holds back all forwarded traffic for a while after a frame ends. Input uses valid/ready with line-start and frame-end markers. Ready is withdrawn while a timer holds the word or while the slicer is still emptying the previous word. Words for disabled threads are always taken and dropped.

Top module: `pix_width_conv`

## Requirements
- R1: After reset every context is disabled, `out_valid` is 0 and `in_ready` is 1.
- R2: A write with `ctx_wr_valid` high stores the enable bit, size code, virtual channel and data type into the entry chosen by `ctx_wr_idx` at the next clock edge.
- R3: The size code selects the slicing. Code 0 gives sixteen 8-bit slices, code 1 gives eight 16-bit slices, and codes 2 and 3 give four 32-bit slices. Slice k is bits [k*M+M-1 : k*M] of the word, sent lowest first and zero-extended in `out_data`.
- R4: Every slice carries, on `out_vc` and `out_dtype`, the values in the thread's context when the word was accepted.
- R5: A word whose thread context is disabled sees `in_ready` high whatever the slicer and timers are doing, and it produces no output.
- R6: A word for an enabled thread accepted at clock edge t presents slice k with `out_valid` high in the cycle after edge t+k. Ready returns while the last slice is shown, so consecutive words stream with no gap.
- R7: `out_sol` is high only on slice 0 of a word accepted with `in_sol`. `out_eof` is high only on the last slice of a word accepted with `in_eof`.
- R8: An enabled line-start word is accepted no sooner than max(`line_gap`,1) clock edges after the previous enabled line-start word was accepted.
- R9: After an enabled frame-end word is accepted, no enabled word is accepted until max(`frame_gap`,1) clock edges have passed.
- R10: A running line timer does not hold back enabled words that lack `in_sol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_wr_valid | input | 1 | Context write strobe |
| ctx_wr_idx | input | 5 | Context entry to write |
| ctx_wr_enable | input | 1 | Enable bit to store |
| ctx_wr_size | input | 2 | Slice size code to store |
| ctx_wr_vc | input | 2 | Virtual channel to store |
| ctx_wr_dtype | input | 6 | Data type to store |
| line_gap | input | 16 | Minimum clock edges between line starts |
| frame_gap | input | 16 | Minimum clock edges from frame end to next word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted this cycle when valid |
| in_data | input | 128 | Input pixel word |
| in_thread | input | 5 | Thread ID of the input word |
| in_sol | input | 1 | Word begins a line |
| in_eof | input | 1 | Word ends a frame |
| out_valid | output | 1 | Output slice valid |
| out_data | output | 32 | Output slice, zero-extended |
| out_vc | output | 2 | Virtual channel of the slice |
| out_dtype | output | 6 | Data type of the slice |
| out_sol | output | 1 | First slice of a line-start word |
| out_eof | output | 1 | Last slice of a frame-end word |

## Verification
`in_ready` is a same-cycle function of the inputs and the current state. The first slice appears one edge after the accepting edge, and each further slice follows one edge later. A context write takes effect on the word presented after the writing edge. The bench changes inputs just after a rising edge and compares at the falling edge. Its model holds the slices due in order and pops one per cycle, so each comparison falls in the cycle where that result is due. Pacing is measured by counting edges between the acceptances the bench records, and those counts are compared with the programmed gaps.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  localparam int THREADS = 32;
  localparam int IN_W    = 128;
  localparam int OUT_W   = 32;
  localparam int SZ_W    = 2;
  localparam int VC_W    = 2;
  localparam int DT_W    = 6;
  localparam int GAP_W   = 16;

  localparam int TID_W      = $clog2(THREADS);
  localparam int LANES      = IN_W / OUT_W;
  localparam int MAX_SLICES = IN_W / 8;
  localparam int IDX_W      = $clog2(MAX_SLICES);

  typedef struct packed {
    logic            en;
    logic [SZ_W-1:0] size;
    logic [VC_W-1:0] vc;
    logic [DT_W-1:0] dt;
  } ctx_t;

  // number of slices a word yields for a size code
  function automatic logic [IDX_W:0] slice_total(input logic [SZ_W-1:0] size);
    case (size)
      2'd0:    return (IDX_W+1)'(MAX_SLICES);
      2'd1:    return (IDX_W+1)'(IN_W / 16);
      default: return (IDX_W+1)'(LANES);
    endcase
  endfunction

  // slice idx of word w, zero-extended to the output width
  function automatic logic [OUT_W-1:0] slice_pick(input logic [IN_W-1:0] w,
                                                  input logic [SZ_W-1:0] size,
                                                  input logic [IDX_W-1:0] idx);
    case (size)
      2'd0:    return OUT_W'(w[{idx, 3'b000} +: 8]);
      2'd1:    return OUT_W'(w[{idx[2:0], 4'b0000} +: 16]);
      default: return w[{idx[1:0], 5'b00000} +: OUT_W];
    endcase
  endfunction

  // timer reload: a gap of g edges counts g-1 down to zero
  function automatic logic [GAP_W-1:0] gap_load(input logic [GAP_W-1:0] g);
    return (g == '0) ? '0 : g - GAP_W'(1);
  endfunction
endpackage

// File: rtl/pwc_ctx_table.sv
module pwc_ctx_table
  import pwc_pkg::*;
#(
  parameter int N_CTX = THREADS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [TID_W-1:0] wr_idx,
  input  ctx_t             wr_data,
  input  logic [TID_W-1:0] rd_idx,
  output ctx_t             rd_data
);
  ctx_t entry [N_CTX];

  for (genvar g = 0; g < N_CTX; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        entry[g] <= '0;
      else if (wr_valid && (wr_idx == TID_W'(g)))
        entry[g] <= wr_data;
    end
  end

  assign rd_data = entry[rd_idx];
endmodule

// File: rtl/pwc_slicer.sv
module pwc_slicer
  import pwc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IN_W-1:0]  word,
  input  ctx_t             ctx,
  input  logic             sol,
  input  logic             eof,
  output logic             busy,
  output logic             last,
  output logic [SZ_W-1:0]  cur_size,
  output logic [OUT_W-1:0] out_data,
  output logic [VC_W-1:0]  out_vc,
  output logic [DT_W-1:0]  out_dtype,
  output logic             out_sol,
  output logic             out_eof
);
  logic [IN_W-1:0]  word_q;
  logic [SZ_W-1:0]  size_q;
  logic [VC_W-1:0]  vc_q;
  logic [DT_W-1:0]  dt_q;
  logic             sol_q;
  logic             eof_q;
  logic [IDX_W-1:0] idx_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      word_q <= '0;
      size_q <= '0;
      vc_q   <= '0;
      dt_q   <= '0;
      sol_q  <= 1'b0;
      eof_q  <= 1'b0;
    end else if (load) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      word_q <= word;
      size_q <= ctx.size;
      vc_q   <= ctx.vc;
      dt_q   <= ctx.dt;
      sol_q  <= sol;
      eof_q  <= eof;
    end else if (busy_q) begin
      if (last) busy_q <= 1'b0;
      else      idx_q  <= idx_q + IDX_W'(1);
    end
  end

  assign busy      = busy_q;
  assign last      = busy_q && ({1'b0, idx_q} == slice_total(size_q) - (IDX_W+1)'(1));
  assign cur_size  = size_q;
  assign out_data  = busy_q ? slice_pick(word_q, size_q, idx_q) : '0;
  assign out_vc    = vc_q;
  assign out_dtype = dt_q;
  assign out_sol   = busy_q && sol_q && (idx_q == '0);
  assign out_eof   = last && eof_q;
endmodule

// File: rtl/pwc_pacer.sv
module pwc_pacer
  import pwc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             sol,
  input  logic             eof,
  input  logic [GAP_W-1:0] line_gap,
  input  logic [GAP_W-1:0] frame_gap,
  output logic             line_open,
  output logic             frame_open
);
  logic [GAP_W-1:0] line_cnt;
  logic [GAP_W-1:0] frame_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      line_cnt <= '0;
    else if (acc_en && sol)
      line_cnt <= gap_load(line_gap);
    else if (line_cnt != '0)
      line_cnt <= line_cnt - GAP_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      frame_cnt <= '0;
    else if (acc_en && eof)
      frame_cnt <= gap_load(frame_gap);
    else if (frame_cnt != '0)
      frame_cnt <= frame_cnt - GAP_W'(1);
  end

  assign line_open  = (line_cnt == '0);
  assign frame_open = (frame_cnt == '0);
endmodule

// File: rtl/pix_width_conv.sv
module pix_width_conv
  import pwc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctx_wr_valid,
  input  logic [TID_W-1:0] ctx_wr_idx,
  input  logic             ctx_wr_enable,
  input  logic [SZ_W-1:0]  ctx_wr_size,
  input  logic [VC_W-1:0]  ctx_wr_vc,
  input  logic [DT_W-1:0]  ctx_wr_dtype,
  input  logic [GAP_W-1:0] line_gap,
  input  logic [GAP_W-1:0] frame_gap,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  input  logic [TID_W-1:0] in_thread,
  input  logic             in_sol,
  input  logic             in_eof,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic [VC_W-1:0]  out_vc,
  output logic [DT_W-1:0]  out_dtype,
  output logic             out_sol,
  output logic             out_eof
);
  ctx_t            wr_ctx;
  ctx_t            rd_ctx;
  logic            rd_en;
  logic            busy;
  logic            last;
  logic            slicer_free;
  logic            line_open;
  logic            frame_open;
  logic            fwd_ready;
  logic            accept;
  logic            acc_en;
  logic [SZ_W-1:0] cur_size;

  assign wr_ctx = '{en: ctx_wr_enable, size: ctx_wr_size, vc: ctx_wr_vc, dt: ctx_wr_dtype};

  pwc_ctx_table #(.N_CTX(THREADS)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (ctx_wr_valid),
    .wr_idx   (ctx_wr_idx),
    .wr_data  (wr_ctx),
    .rd_idx   (in_thread),
    .rd_data  (rd_ctx)
  );

  assign rd_en       = rd_ctx.en;
  assign slicer_free = !busy || last;
  assign fwd_ready   = slicer_free && frame_open && (!in_sol || line_open);
  assign in_ready    = !rd_en || fwd_ready;
  assign accept      = in_valid && in_ready;
  assign acc_en      = accept && rd_en;

  pwc_slicer u_slicer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (acc_en),
    .word      (in_data),
    .ctx       (rd_ctx),
    .sol       (in_sol),
    .eof       (in_eof),
    .busy      (busy),
    .last      (last),
    .cur_size  (cur_size),
    .out_data  (out_data),
    .out_vc    (out_vc),
    .out_dtype (out_dtype),
    .out_sol   (out_sol),
    .out_eof   (out_eof)
  );

  assign out_valid = busy;

  pwc_pacer u_pacer (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_en     (acc_en),
    .sol        (in_sol),
    .eof        (in_eof),
    .line_gap   (line_gap),
    .frame_gap  (frame_gap),
    .line_open  (line_open),
    .frame_open (frame_open)
  );
endmodule

// File: rtl/pwc_checker.sv
module pwc_checker
  import pwc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_sol,
  input logic             in_eof,
  input logic [GAP_W-1:0] line_gap,
  input logic [GAP_W-1:0] frame_gap,
  input logic             out_valid,
  input logic             out_sol,
  input logic             out_eof,
  input logic [OUT_W-1:9] out_hi,
  input logic             out_b8,
  input logic             acc_en,
  input logic             rd_en,
  input logic [SZ_W-1:0]  cur_size
);
  logic [GAP_W:0] since_sol;
  logic [GAP_W:0] since_eof;
  logic           sol_seen;
  logic           eof_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_sol <= '0;
      sol_seen  <= 1'b0;
    end else if (acc_en && in_sol) begin
      since_sol <= (GAP_W+1)'(1);
      sol_seen  <= 1'b1;
    end else if (since_sol != '1) begin
      since_sol <= since_sol + (GAP_W+1)'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_eof <= '0;
      eof_seen  <= 1'b0;
    end else if (acc_en && in_eof) begin
      since_eof <= (GAP_W+1)'(1);
      eof_seen  <= 1'b1;
    end else if (since_eof != '1) begin
      since_eof <= since_eof + (GAP_W+1)'(1);
    end
  end

  p_line_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && in_sol && sol_seen) |-> (since_sol >= {1'b0, line_gap}));

  p_frame_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && eof_seen) |-> (since_eof >= {1'b0, frame_gap}));

  p_disabled_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rd_en) |-> in_ready);

  p_load_shows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> out_valid);

  p_marks_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sol || out_eof) |-> out_valid);

  p_byte_zero_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cur_size == 2'd0) |-> (out_hi == '0 && !out_b8));
endmodule

bind pix_width_conv pwc_checker u_pwc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_sol    (in_sol),
  .in_eof    (in_eof),
  .line_gap  (line_gap),
  .frame_gap (frame_gap),
  .out_valid (out_valid),
  .out_sol   (out_sol),
  .out_eof   (out_eof),
  .out_hi    (out_data[31:9]),
  .out_b8    (out_data[8]),
  .acc_en    (acc_en),
  .rd_en     (rd_en),
  .cur_size  (cur_size)
);

// File: tb/pix_width_conv_bench.sv
module pix_width_conv_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ctx_wr_valid = 1'b0;
  logic [4:0]   ctx_wr_idx = '0;
  logic         ctx_wr_enable = 1'b0;
  logic [1:0]   ctx_wr_size = '0;
  logic [1:0]   ctx_wr_vc = '0;
  logic [5:0]   ctx_wr_dtype = '0;
  logic [15:0]  line_gap = '0;
  logic [15:0]  frame_gap = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic [4:0]   in_thread = '0;
  logic         in_sol = 1'b0;
  logic         in_eof = 1'b0;
  logic         out_valid;
  logic [31:0]  out_data;
  logic [1:0]   out_vc;
  logic [5:0]   out_dtype;
  logic         out_sol;
  logic         out_eof;

  pix_width_conv u_pix_width_conv (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n_out = 0;
  int acc_cyc = 0;
  int waited = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // reference model state
  typedef struct {
    logic [31:0] d;
    logic [1:0]  vc;
    logic [5:0]  dt;
    logic        sol;
    logic        eof;
  } slice_t;
  slice_t q[$];
  bit       m_en [32];
  int       m_sz [32];
  int       m_vc [32];
  int       m_dt [32];
  int       lcnt = 0;
  int       fcnt = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      q.delete();
      lcnt = 0;
      fcnt = 0;
      for (int i = 0; i < 32; i++) begin
        m_en[i] = 0; m_sz[i] = 0; m_vc[i] = 0; m_dt[i] = 0;
      end
    end else begin
      bit    en;
      bit    free;
      bit    rdy;
      bit    acc;
      string rtag;
      en   = m_en[in_thread];
      free = (q.size() <= 1) && (fcnt == 0) && !(in_sol && lcnt != 0);
      rdy  = !en || free;
      if (!en) rtag = "R5";
      else if (in_sol && lcnt != 0) rtag = "R8";
      else if (fcnt != 0) rtag = "R9";
      else if (lcnt != 0) rtag = "R10";
      else rtag = "R6";
      chk(in_ready == rdy, rtag, "in_ready", in_ready, rdy);
      if (out_valid) n_out++;
      if (q.size() == 0) begin
        chk(out_valid == 1'b0, "R6", "out_valid idle", out_valid, 0);
      end else begin
        chk(out_valid == 1'b1, "R6", "out_valid busy", out_valid, 1);
        chk(out_data == q[0].d, "R3", "out_data", out_data, q[0].d);
        chk(out_vc == q[0].vc && out_dtype == q[0].dt, "R4", "vc/dtype",
            {out_vc, out_dtype}, {q[0].vc, q[0].dt});
        chk(out_sol == q[0].sol && out_eof == q[0].eof, "R7", "sol/eof",
            {out_sol, out_eof}, {q[0].sol, q[0].eof});
        void'(q.pop_front());
      end
      acc = in_valid && rdy;
      if (lcnt != 0) lcnt--;
      if (fcnt != 0) fcnt--;
      if (acc && en) begin
        int bits;
        int n;
        bits = (m_sz[in_thread] == 0) ? 8 : (m_sz[in_thread] == 1) ? 16 : 32;
        n = 128 / bits;
        for (int k = 0; k < n; k++) begin
          slice_t s;
          logic [127:0] sh;
          sh    = in_data >> (k * bits);
          s.d   = (bits == 32) ? sh[31:0] : (bits == 16) ? {16'h0, sh[15:0]} : {24'h0, sh[7:0]};
          s.vc  = 2'(m_vc[in_thread]);
          s.dt  = 6'(m_dt[in_thread]);
          s.sol = in_sol && (k == 0);
          s.eof = in_eof && (k == n - 1);
          q.push_back(s);
        end
        if (in_sol) lcnt = (line_gap == 0) ? 0 : int'(line_gap) - 1;
        if (in_eof) fcnt = (frame_gap == 0) ? 0 : int'(frame_gap) - 1;
      end
      if (ctx_wr_valid) begin
        m_en[ctx_wr_idx] = ctx_wr_enable;
        m_sz[ctx_wr_idx] = int'(ctx_wr_size);
        m_vc[ctx_wr_idx] = int'(ctx_wr_vc);
        m_dt[ctx_wr_idx] = int'(ctx_wr_dtype);
      end
    end
  end

  task automatic wr_ctx(input int idx, input bit en, input int sz, input int vc, input int dt);
    ctx_wr_valid  = 1'b1;
    ctx_wr_idx    = 5'(idx);
    ctx_wr_enable = en;
    ctx_wr_size   = 2'(sz);
    ctx_wr_vc     = 2'(vc);
    ctx_wr_dtype  = 6'(dt);
    @(posedge clk); #1;
    ctx_wr_valid  = 1'b0;
  endtask

  task automatic send(input int tid, input bit sol, input bit eof);
    in_valid  = 1'b1;
    in_thread = 5'(tid);
    in_sol    = sol;
    in_eof    = eof;
    in_data   = {$urandom, $urandom, $urandom, $urandom};
    waited    = 0;
    @(negedge clk);
    while (!in_ready) begin
      waited++;
      @(negedge clk);
    end
    acc_cyc = cyc;
    @(posedge clk); #1;
    in_valid = 1'b0;
    in_sol   = 1'b0;
    in_eof   = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int t1;
    repeat (5) @(posedge clk);
    #1;
    rst_n = 1'b1;
    in_thread = 5'd5;
    @(negedge clk);
    // R1: reset state, everything disabled
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    @(posedge clk); #1;

    wr_ctx(3, 1, 0, 1, 6'h2A);
    wr_ctx(7, 1, 1, 2, 6'h2B);
    wr_ctx(12, 1, 2, 3, 6'h1E);
    wr_ctx(9, 1, 3, 0, 6'h12);

    // R2: programmed thread 3 now forwards sixteen byte slices
    n_out = 0;
    send(3, 1, 0);
    idle(24);
    chk(n_out == 16, "R2", "slices from programmed thread", n_out, 16);

    // mixed sizes back to back
    send(7, 1, 0);
    send(12, 0, 0);
    send(9, 0, 0);
    send(3, 0, 1);
    idle(24);

    // R5: disabled thread taken while the slicer is busy
    send(12, 1, 0);
    send(20, 0, 0);
    chk(waited == 0, "R5", "disabled word waited", waited, 0);
    send(12, 0, 1);
    idle(24);

    // R8 / R10: line pacing
    line_gap = 16'd20;
    idle(40);
    send(12, 1, 0);
    t1 = acc_cyc;
    send(12, 0, 0);
    chk(acc_cyc - t1 == 4, "R10", "non-line-start word gap", acc_cyc - t1, 4);
    send(12, 1, 0);
    chk(acc_cyc - t1 == 20, "R8", "line start spacing", acc_cyc - t1, 20);
    idle(30);
    line_gap = 16'd0;

    // R9: frame pacing
    frame_gap = 16'd15;
    idle(40);
    send(7, 1, 1);
    t1 = acc_cyc;
    send(7, 0, 0);
    chk(acc_cyc - t1 == 15, "R9", "frame end spacing", acc_cyc - t1, 15);
    idle(30);
    frame_gap = 16'd0;

    // R3: size code 3 behaves as 32-bit slices
    wr_ctx(5, 1, 3, 2, 6'h2C);
    n_out = 0;
    send(5, 1, 1);
    idle(10);
    chk(n_out == 4, "R3", "slices for size code 3", n_out, 4);

    // R5: disabling a context drops its words
    wr_ctx(3, 0, 0, 1, 6'h2A);
    n_out = 0;
    send(3, 1, 0);
    idle(10);
    chk(n_out == 0, "R5", "slices from disabled thread", n_out, 0);

    idle(5);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule